// File: doc/BRIEF.md
# Domain Reset and Isolation Sequencer

This block is a hardware state machine that resets one subsystem domain of a chip without leaving its bus interfaces open during the reset. Each sequence first raises isolation requests toward the bridges in front of the domain. It then asserts the domain reset line and holds it for fixed times. Last, it releases the reset and the isolation in a set order. Three one-cycle command inputs pick the sequence:

- a processing-subsystem-only reset;
- a full-power-domain reset;
- a lockstep real-time-processor reset.

Acknowledge vectors come back from the isolation bridges. The sequencer polls them against a mask, and each poll has a bounded timeout. A timed-out poll never stops a sequence. The sequence carries on and records the event in a sticky flag. The fixed waits and the poll limit are parameters, and both default to 15 cycles.

The processing-subsystem-only sequence ends with its reset asserted and never releases it, because the sequencer is expected to be reset together with that domain. The other two sequences return to idle and mark the end with a one-cycle done pulse. Edge E0 is the clock edge that accepts a command, and Ek is the k-th edge after it. W is the wait length and P is the poll limit.

Top module: `rstseq_top`

## Requirements
- R1: While `rstN` is low, all isolation requests, all three domain resets, `busy`, `done` and `timeoutFlags` are 0.
- R2: A processing-subsystem-only command raises all four bits of `psIsoReq` on E0. Bit 0 is the low-power master, bit 1 the low-power slave, bit 2 the full-power master and bit 3 the full-power slave.
- R3: A poll succeeds only when every bit of its mask is set in the acknowledge vector. A partial acknowledge is handled as no acknowledge, and the poll ends by timeout on edge P after it started.
- R4: The processing-subsystem-only sequence asserts `psOnlyRst` on the edge its poll ends: E1 or later with a full acknowledge, or EP on timeout. After that, `psOnlyRst`, `psIsoReq` and `busy` stay high until `rstN` goes low.
- R5: A timed-out poll lets the sequence continue and sets a sticky bit of `timeoutFlags`. Bit 0 is the `psIsoAck` poll, bit 1 the master poll (`rpuIsoAck[1:0]`) and bit 2 the slave poll (`rpuIsoAck[3:2]`). All bits clear on the edge that accepts the next command.
- R6: The full-power-domain sequence ignores all acknowledges. It sets `fpdIsoCtl` to 2'b11 on E0, asserts `fpdRst` on EW, clears `fpdIsoCtl` on E2W, deasserts `fpdRst` on E3W and finishes on E4W.
- R7: The lockstep sequence runs in this order:
  - it sets `rpuIsoReq[1:0]` (masters) on E0 and polls them;
  - when that poll ends it sets `rpuIsoReq[3:2]` (slaves) and polls them;
  - when the second poll ends it clears the master requests and asserts `rpuRst` on the same edge;
  - it deasserts `rpuRst` W edges later;
  - after W more edges it clears the slave requests and finishes.
- R8: `done` is high for exactly one cycle, on the edge where the full-power-domain or lockstep sequence finishes, and `busy` falls on that same edge.
- R9: Commands that arrive while `busy` is high have no effect on any output.
- R10: When commands arrive together in the idle state, the processing-subsystem-only command wins over the full-power-domain command, which wins over the lockstep command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| cmdPsOnly | input | 1 | Start the processing-subsystem-only reset |
| cmdFpd | input | 1 | Start the full-power-domain reset |
| cmdRpu | input | 1 | Start the lockstep processor reset |
| psIsoAck | input | 4 | Acknowledges for the four processing-subsystem isolation requests |
| rpuIsoAck | input | 4 | Lockstep bridge acknowledges: [1:0] masters, [3:2] slaves |
| psIsoReq | output | 4 | Processing-subsystem isolation requests |
| fpdIsoCtl | output | 2 | Full-power-domain isolation controls |
| rpuIsoReq | output | 4 | Lockstep isolation requests: [1:0] masters, [3:2] slaves |
| psOnlyRst | output | 1 | Processing-subsystem-only reset, never self-released |
| fpdRst | output | 1 | Full-power-domain reset |
| rpuRst | output | 1 | Lockstep processor reset |
| busy | output | 1 | A sequence is in progress or the subsystem reset is held |
| done | output | 1 | One-cycle end pulse of the full-power-domain or lockstep sequence |
| timeoutFlags | output | 3 | Sticky per-poll timeout record |

## Verification
The hardest case to reach is a sequence that times out on one poll and then succeeds on the next poll within the same run. The bench reaches it by holding acknowledge vectors with chosen bits missing. A vector with one master bit clear gives a master timeout followed by a slave success. A vector with both master bits set and both slave bits clear gives the reverse. A partial processing-subsystem acknowledge shows that a poll only succeeds on the full mask. Commands pulsed in the middle of a sequence, and commands raised together, check that requests are ignored while busy and that priority is applied.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  localparam int PS_ISO_W   = 4;
  localparam int FPD_ISO_W  = 2;
  localparam int RPU_SIDE_W = 2;
  localparam int RPU_ISO_W  = 2 * RPU_SIDE_W;
  localparam int TMO_W      = 3;

  localparam int TMO_PS  = 0;
  localparam int TMO_RPM = 1;
  localparam int TMO_RPS = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PS_POLL,
    ST_PS_HOLD,
    ST_FPD_ISO,
    ST_FPD_RST,
    ST_FPD_UNISO,
    ST_FPD_REL,
    ST_RPU_MPOLL,
    ST_RPU_SPOLL,
    ST_RPU_RST,
    ST_RPU_REL
  } seqState_t;

  typedef struct packed {
    logic             setPsReq;
    logic             setPsRst;
    logic             setFpdIso;
    logic             clrFpdIso;
    logic             setFpdRst;
    logic             clrFpdRst;
    logic             setRpuMReq;
    logic             clrRpuMReq;
    logic             setRpuSReq;
    logic             clrRpuSReq;
    logic             setRpuRst;
    logic             clrRpuRst;
    logic             cntClr;
    logic             tmoClr;
    logic [TMO_W-1:0] tmoSet;
    logic             donePulse;
  } seqStrobe_t;

endpackage

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdPsOnly,
  input  logic       cmdFpd,
  input  logic       cmdRpu,
  input  logic       waitHit,
  input  logic       pollHit,
  input  logic       psAckAll,
  input  logic       rpuMAckAll,
  input  logic       rpuSAckAll,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdPsOnly) begin
          strobe.setPsReq = 1'b1;
          strobe.cntClr   = 1'b1;
          strobe.tmoClr   = 1'b1;
          stateNxt        = ST_PS_POLL;
        end else if (cmdFpd) begin
          strobe.setFpdIso = 1'b1;
          strobe.cntClr    = 1'b1;
          strobe.tmoClr    = 1'b1;
          stateNxt         = ST_FPD_ISO;
        end else if (cmdRpu) begin
          strobe.setRpuMReq = 1'b1;
          strobe.cntClr     = 1'b1;
          strobe.tmoClr     = 1'b1;
          stateNxt          = ST_RPU_MPOLL;
        end
      end
      ST_PS_POLL: begin
        if (psAckAll || pollHit) begin
          strobe.setPsRst       = 1'b1;
          strobe.tmoSet[TMO_PS] = !psAckAll;
          stateNxt              = ST_PS_HOLD;
        end
      end
      ST_PS_HOLD: stateNxt = ST_PS_HOLD;
      ST_FPD_ISO: begin
        if (waitHit) begin
          strobe.setFpdRst = 1'b1;
          strobe.cntClr    = 1'b1;
          stateNxt         = ST_FPD_RST;
        end
      end
      ST_FPD_RST: begin
        if (waitHit) begin
          strobe.clrFpdIso = 1'b1;
          strobe.cntClr    = 1'b1;
          stateNxt         = ST_FPD_UNISO;
        end
      end
      ST_FPD_UNISO: begin
        if (waitHit) begin
          strobe.clrFpdRst = 1'b1;
          strobe.cntClr    = 1'b1;
          stateNxt         = ST_FPD_REL;
        end
      end
      ST_FPD_REL: begin
        if (waitHit) begin
          strobe.donePulse = 1'b1;
          stateNxt         = ST_IDLE;
        end
      end
      ST_RPU_MPOLL: begin
        if (rpuMAckAll || pollHit) begin
          strobe.setRpuSReq      = 1'b1;
          strobe.tmoSet[TMO_RPM] = !rpuMAckAll;
          strobe.cntClr          = 1'b1;
          stateNxt               = ST_RPU_SPOLL;
        end
      end
      ST_RPU_SPOLL: begin
        if (rpuSAckAll || pollHit) begin
          strobe.clrRpuMReq      = 1'b1;
          strobe.setRpuRst       = 1'b1;
          strobe.tmoSet[TMO_RPS] = !rpuSAckAll;
          strobe.cntClr          = 1'b1;
          stateNxt               = ST_RPU_RST;
        end
      end
      ST_RPU_RST: begin
        if (waitHit) begin
          strobe.clrRpuRst = 1'b1;
          strobe.cntClr    = 1'b1;
          stateNxt         = ST_RPU_REL;
        end
      end
      ST_RPU_REL: begin
        if (waitHit) begin
          strobe.clrRpuSReq = 1'b1;
          strobe.donePulse  = 1'b1;
          stateNxt          = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R9: no sequence start strobe may be issued while a sequence is running
  assert_busy_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.setPsReq || strobe.setFpdIso || strobe.setRpuMReq || strobe.tmoClr));

  // R10: a simultaneous subsystem-only command always selects that sequence
  assert_ps_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdPsOnly) |=> (state == ST_PS_POLL));

endmodule

// File: rtl/rstseq_dpath.sv
module rstseq_dpath
  import rstseq_pkg::*;
#(
  parameter int WAIT_CYCLES = 15,
  parameter int POLL_CYCLES = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [PS_ISO_W-1:0]   psIsoAck,
  input  logic [RPU_ISO_W-1:0]  rpuIsoAck,
  output logic [PS_ISO_W-1:0]   psIsoReq,
  output logic [FPD_ISO_W-1:0]  fpdIsoCtl,
  output logic [RPU_ISO_W-1:0]  rpuIsoReq,
  output logic                  psOnlyRst,
  output logic                  fpdRst,
  output logic                  rpuRst,
  output logic                  done,
  output logic [TMO_W-1:0]      timeoutFlags,
  output logic                  waitHit,
  output logic                  pollHit,
  output logic                  psAckAll,
  output logic                  rpuMAckAll,
  output logic                  rpuSAckAll
);

  localparam int CNT_MAX = ((WAIT_CYCLES > POLL_CYCLES) ? WAIT_CYCLES : POLL_CYCLES) - 1;
  localparam int CNT_W   = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]      cnt;
  logic [RPU_SIDE_W-1:0] rpuMReq, rpuSReq;

  // shared wait / poll counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (strobe.cntClr)             cnt <= '0;
    else if (cnt != CNT_W'(CNT_MAX))    cnt <= cnt + 1'b1;
  end

  assign waitHit = (cnt == CNT_W'(WAIT_CYCLES - 1));
  assign pollHit = (cnt == CNT_W'(POLL_CYCLES - 1));

  // acknowledge masks: success needs every bit of the mask
  assign psAckAll   = &psIsoAck;
  assign rpuMAckAll = &rpuIsoAck[RPU_SIDE_W-1:0];
  assign rpuSAckAll = &rpuIsoAck[RPU_ISO_W-1:RPU_SIDE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psIsoReq  <= '0;
      psOnlyRst <= 1'b0;
    end else begin
      if (strobe.setPsReq) psIsoReq  <= '1;
      if (strobe.setPsRst) psOnlyRst <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpdIsoCtl <= '0;
      fpdRst    <= 1'b0;
    end else begin
      if (strobe.setFpdIso)      fpdIsoCtl <= '1;
      else if (strobe.clrFpdIso) fpdIsoCtl <= '0;
      if (strobe.setFpdRst)      fpdRst    <= 1'b1;
      else if (strobe.clrFpdRst) fpdRst    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rpuMReq <= '0;
      rpuSReq <= '0;
      rpuRst  <= 1'b0;
    end else begin
      if (strobe.setRpuMReq)      rpuMReq <= '1;
      else if (strobe.clrRpuMReq) rpuMReq <= '0;
      if (strobe.setRpuSReq)      rpuSReq <= '1;
      else if (strobe.clrRpuSReq) rpuSReq <= '0;
      if (strobe.setRpuRst)       rpuRst  <= 1'b1;
      else if (strobe.clrRpuRst)  rpuRst  <= 1'b0;
    end
  end

  assign rpuIsoReq = {rpuSReq, rpuMReq};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobe.donePulse;
  end

  // one sticky flag per poll
  for (genvar i = 0; i < TMO_W; i++) begin : gTmo
    logic tmoBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 tmoBit <= 1'b0;
      else if (strobe.tmoClr)    tmoBit <= 1'b0;
      else if (strobe.tmoSet[i]) tmoBit <= 1'b1;
    end
    assign timeoutFlags[i] = tmoBit;
  end

  assert_ps_req_together_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(psIsoReq[0]) |-> (psIsoReq == '1));

  assert_ps_rst_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    psOnlyRst |=> (psOnlyRst && psIsoReq == '1));

  assert_ps_tmo_with_rst_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlags[TMO_PS]) |-> $rose(psOnlyRst));

  assert_fpd_rst_isolated_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fpdRst) |-> (fpdIsoCtl == '1));

  assert_fpd_release_unisolated_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fpdRst) |-> (fpdIsoCtl == '0));

  assert_rpu_rst_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rpuRst) |-> (rpuSReq == '1 && rpuMReq == '0));

  assert_rpu_slave_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    rpuRst |-> (rpuSReq == '1));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_one_domain_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({psOnlyRst, fpdRst, rpuRst}) <= 1);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int WAIT_CYCLES = 15,
  parameter int POLL_CYCLES = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdPsOnly,
  input  logic                 cmdFpd,
  input  logic                 cmdRpu,
  input  logic [PS_ISO_W-1:0]  psIsoAck,
  input  logic [RPU_ISO_W-1:0] rpuIsoAck,
  output logic [PS_ISO_W-1:0]  psIsoReq,
  output logic [FPD_ISO_W-1:0] fpdIsoCtl,
  output logic [RPU_ISO_W-1:0] rpuIsoReq,
  output logic                 psOnlyRst,
  output logic                 fpdRst,
  output logic                 rpuRst,
  output logic                 busy,
  output logic                 done,
  output logic [TMO_W-1:0]     timeoutFlags
);

  seqStrobe_t strobe;
  logic waitHit, pollHit, psAckAll, rpuMAckAll, rpuSAckAll;

  rstseq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdPsOnly  (cmdPsOnly),
    .cmdFpd     (cmdFpd),
    .cmdRpu     (cmdRpu),
    .waitHit    (waitHit),
    .pollHit    (pollHit),
    .psAckAll   (psAckAll),
    .rpuMAckAll (rpuMAckAll),
    .rpuSAckAll (rpuSAckAll),
    .strobe     (strobe),
    .busy       (busy)
  );

  rstseq_dpath #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .POLL_CYCLES (POLL_CYCLES)
  ) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .psIsoAck     (psIsoAck),
    .rpuIsoAck    (rpuIsoAck),
    .psIsoReq     (psIsoReq),
    .fpdIsoCtl    (fpdIsoCtl),
    .rpuIsoReq    (rpuIsoReq),
    .psOnlyRst    (psOnlyRst),
    .fpdRst       (fpdRst),
    .rpuRst       (rpuRst),
    .done         (done),
    .timeoutFlags (timeoutFlags),
    .waitHit      (waitHit),
    .pollHit      (pollHit),
    .psAckAll     (psAckAll),
    .rpuMAckAll   (rpuMAckAll),
    .rpuSAckAll   (rpuSAckAll)
  );

endmodule

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;

  localparam int W = 15;
  localparam int P = 15;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdPsOnly, cmdFpd, cmdRpu;
  logic [3:0] psIsoAck, rpuIsoAck;
  logic [3:0] psIsoReq, rpuIsoReq;
  logic [1:0] fpdIsoCtl;
  logic       psOnlyRst, fpdRst, rpuRst, busy, done;
  logic [2:0] timeoutFlags;

  always #2 clk = ~clk;

  rstseq_top #(.WAIT_CYCLES(W), .POLL_CYCLES(P)) dut (
    .clk(clk), .rstN(rstN), .cmdPsOnly(cmdPsOnly), .cmdFpd(cmdFpd), .cmdRpu(cmdRpu),
    .psIsoAck(psIsoAck), .rpuIsoAck(rpuIsoAck), .psIsoReq(psIsoReq),
    .fpdIsoCtl(fpdIsoCtl), .rpuIsoReq(rpuIsoReq), .psOnlyRst(psOnlyRst),
    .fpdRst(fpdRst), .rpuRst(rpuRst), .busy(busy), .done(done),
    .timeoutFlags(timeoutFlags)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          c;
    logic [17:0] v;
    string       tag;
  } item_t;

  item_t q[$];
  int    nVec = 0;
  int    nBad = 0;
  bit    finished = 1'b0;

  wire [17:0] act = {psIsoReq, fpdIsoCtl, rpuIsoReq, psOnlyRst, fpdRst, rpuRst,
                     busy, done, timeoutFlags};

  function automatic logic [17:0] mk(logic [3:0] pr, logic [1:0] fi, logic [3:0] rr,
                                     logic prst, logic frst, logic rrst,
                                     logic b, logic d, logic [2:0] t);
    return {pr, fi, rr, prst, frst, rrst, b, d, t};
  endfunction

  task automatic expectAt(int c, logic [17:0] v, string tag);
    item_t it;
    it.c = c; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pop and compare expected items when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].c <= cyc) begin
      item_t it;
      it = q.pop_front();
      nVec++;
      if (it.c != cyc || act !== it.v) begin
        nBad++;
        $display("FAIL %s at cycle %0d: actual %h expected %h", it.tag, cyc, act, it.v);
      end
    end
  end

  task automatic startCmd(logic [2:0] c, output int c0);
    @(negedge clk);
    {cmdPsOnly, cmdFpd, cmdRpu} = c;
    c0 = cyc + 1;
  endtask

  task automatic endCmd();
    @(negedge clk);
    {cmdPsOnly, cmdFpd, cmdRpu} = 3'b000;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    rstN = 1'b0;
    {cmdPsOnly, cmdFpd, cmdRpu} = 3'b000;
    psIsoAck = 4'h0;
    rpuIsoAck = 4'h0;

    // R1: reset state, during and right after reset
    repeat (2) @(negedge clk);
    expectAt(cyc + 1, '0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    expectAt(cyc + 1, '0, "R1 after reset");
    drain();

    // R6 R8 R9 R10: full-power sequence wins over lockstep; late commands ignored
    startCmd(3'b011, c0);
    expectAt(c0,           mk(0, 2'b11, 0, 0, 0, 0, 1, 0, 0), "R10 fpd over rpu");
    expectAt(c0 + W - 1,   mk(0, 2'b11, 0, 0, 0, 0, 1, 0, 0), "R6 iso before rst");
    expectAt(c0 + W,       mk(0, 2'b11, 0, 0, 1, 0, 1, 0, 0), "R6 rst asserted");
    expectAt(c0 + 2*W - 1, mk(0, 2'b11, 0, 0, 1, 0, 1, 0, 0), "R6 iso held");
    expectAt(c0 + 2*W,     mk(0, 2'b00, 0, 0, 1, 0, 1, 0, 0), "R6 iso cleared");
    expectAt(c0 + 3*W - 1, mk(0, 2'b00, 0, 0, 1, 0, 1, 0, 0), "R6 rst held");
    expectAt(c0 + 3*W,     mk(0, 2'b00, 0, 0, 0, 0, 1, 0, 0), "R6 rst released");
    expectAt(c0 + 4*W - 1, mk(0, 2'b00, 0, 0, 0, 0, 1, 0, 0), "R8 not done yet");
    expectAt(c0 + 4*W,     mk(0, 2'b00, 0, 0, 0, 0, 0, 1, 0), "R8 done pulse");
    expectAt(c0 + 4*W + 1, mk(0, 2'b00, 0, 0, 0, 0, 0, 0, 0), "R9 idle, busy cmds ignored");
    expectAt(c0 + 4*W + 3, mk(0, 2'b00, 0, 0, 0, 0, 0, 0, 0), "R9 still idle");
    endCmd();
    waitUntil(c0 + 4);
    cmdRpu = 1'b1;
    @(negedge clk);
    cmdRpu = 1'b0;
    waitUntil(c0 + 20);
    cmdPsOnly = 1'b1;
    @(negedge clk);
    cmdPsOnly = 1'b0;
    drain();

    // R7: lockstep sequence with full acknowledges
    rpuIsoAck = 4'b1111;
    startCmd(3'b001, c0);
    expectAt(c0,           mk(0, 0, 4'b0011, 0, 0, 0, 1, 0, 0), "R7 master req");
    expectAt(c0 + 1,       mk(0, 0, 4'b1111, 0, 0, 0, 1, 0, 0), "R7 slave req");
    expectAt(c0 + 2,       mk(0, 0, 4'b1100, 0, 0, 1, 1, 0, 0), "R7 master clear + rst");
    expectAt(c0 + 2 + W - 1, mk(0, 0, 4'b1100, 0, 0, 1, 1, 0, 0), "R7 rst held");
    expectAt(c0 + 2 + W,   mk(0, 0, 4'b1100, 0, 0, 0, 1, 0, 0), "R7 rst released");
    expectAt(c0 + 2 + 2*W, mk(0, 0, 4'b0000, 0, 0, 0, 0, 1, 0), "R7 slave clear + done");
    expectAt(c0 + 3 + 2*W, mk(0, 0, 4'b0000, 0, 0, 0, 0, 0, 0), "R8 done one cycle");
    endCmd();
    drain();

    // R3 R5: partial master ack times out, slave poll succeeds
    rpuIsoAck = 4'b1101;
    startCmd(3'b001, c0);
    expectAt(c0,           mk(0, 0, 4'b0011, 0, 0, 0, 1, 0, 0), "R3 master req");
    expectAt(c0 + P - 1,   mk(0, 0, 4'b0011, 0, 0, 0, 1, 0, 0), "R3 partial ack not enough");
    expectAt(c0 + P,       mk(0, 0, 4'b1111, 0, 0, 0, 1, 0, 3'b010), "R5 master timeout");
    expectAt(c0 + P + 1,   mk(0, 0, 4'b1100, 0, 0, 1, 1, 0, 3'b010), "R5 continue to rst");
    expectAt(c0 + P + 1 + W,   mk(0, 0, 4'b1100, 0, 0, 0, 1, 0, 3'b010), "R7 release");
    expectAt(c0 + P + 1 + 2*W, mk(0, 0, 4'b0000, 0, 0, 0, 0, 1, 3'b010), "R8 done");
    expectAt(c0 + P + 2 + 2*W, mk(0, 0, 4'b0000, 0, 0, 0, 0, 0, 3'b010), "R5 sticky");
    endCmd();
    drain();

    // R5: next start clears the flags; slave poll times out
    rpuIsoAck = 4'b0011;
    startCmd(3'b001, c0);
    expectAt(c0,           mk(0, 0, 4'b0011, 0, 0, 0, 1, 0, 0), "R5 cleared on start");
    expectAt(c0 + 1,       mk(0, 0, 4'b1111, 0, 0, 0, 1, 0, 0), "R7 master ack ok");
    expectAt(c0 + 1 + P,   mk(0, 0, 4'b1100, 0, 0, 1, 1, 0, 3'b100), "R5 slave timeout");
    expectAt(c0 + 1 + P + 2*W, mk(0, 0, 4'b0000, 0, 0, 0, 0, 1, 3'b100), "R8 done");
    endCmd();
    drain();

    // R3 R4 R5 R9: partial subsystem ack times out, reset held forever
    rpuIsoAck = 4'b0000;
    psIsoAck = 4'b1011;
    startCmd(3'b100, c0);
    expectAt(c0,         mk(4'b1111, 0, 0, 0, 0, 0, 1, 0, 0), "R2 all four req");
    expectAt(c0 + P - 1, mk(4'b1111, 0, 0, 0, 0, 0, 1, 0, 0), "R3 partial ps ack");
    expectAt(c0 + P,     mk(4'b1111, 0, 0, 1, 0, 0, 1, 0, 3'b001), "R4 rst on timeout");
    expectAt(c0 + P + 25, mk(4'b1111, 0, 0, 1, 0, 0, 1, 0, 3'b001), "R9 R4 held, cmds ignored");
    endCmd();
    waitUntil(c0 + P + 5);
    cmdFpd = 1'b1;
    cmdRpu = 1'b1;
    @(negedge clk);
    cmdFpd = 1'b0;
    cmdRpu = 1'b0;
    drain();

    // R1: controller reset clears a held sequence
    rstN = 1'b0;
    expectAt(cyc + 1, '0, "R1 reset clears");
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    drain();

    // R10 R4: all three commands together, full subsystem ack
    psIsoAck = 4'b1111;
    startCmd(3'b111, c0);
    expectAt(c0,      mk(4'b1111, 0, 0, 0, 0, 0, 1, 0, 0), "R10 ps wins");
    expectAt(c0 + 1,  mk(4'b1111, 0, 0, 1, 0, 0, 1, 0, 0), "R4 rst on ack");
    expectAt(c0 + 40, mk(4'b1111, 0, 0, 1, 0, 0, 1, 0, 0), "R4 never released");
    endCmd();
    drain();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule